// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block is the control state machine of a single-wire bus transceiver. It holds one of four operating modes: unpowered, fail-safe, normal and sleep. From that mode it drives the enables of the transmit and receive paths and the switch that controls the external voltage regulator. The slow inputs are timed against a one-microsecond tick supplied from outside. These inputs are the enable pin, the supply-undervoltage flag and the power-up delay. Wake requests arrive as single-cycle pulses from a local wake filter and from a remote (bus) wake filter. Those filters, the analog thresholds and the bus driver sit outside the block.

A host microcontroller leaves sleep by confirming a wake. The block first reaches fail-safe, where the regulator is on but communication is off. While the enable pin stays low, it pulls the receive pin low as a wake interrupt. It also applies a strong pull-down to the transmit pin when the wake was local. Raising enable clears both indications at once, and enable held high through its filter time moves the block to normal. Dropping enable enters sleep only if the transmit input is high when the filtered fall completes.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: Reset, or `vs_low_i` high in any mode, puts the block in unpowered mode on the next edge. `mode_o` encodes unpowered=2'b00, fail-safe=2'b01, normal=2'b10, sleep=2'b11. In unpowered mode every other output is 0.
- R2: In unpowered mode with `vs_low_i` low, the block enters fail-safe on the edge that completes PWRUP_US ticks. `inh_on_o` is 1 from then on, and any earlier wake indication is cleared.
- R3: `en_i` must be high for RISE_US consecutive ticks before it counts as high. Cycles without a tick do not advance the filter, and shorter high pulses are ignored. In fail-safe, a filtered high moves the block to normal one edge after the tick that completes the filter.
- R4: In normal mode `tx_en_o`, `rx_en_o` and `inh_on_o` are all 1. In every other mode `tx_en_o` and `rx_en_o` are 0.
- R5: In normal mode, `en_i` low for FALL_US consecutive ticks, with `txd_i` high on the completing tick, enters sleep on that tick's edge. In sleep `inh_on_o` is 0. A shorter low pulse leaves the mode unchanged.
- R6: If `txd_i` is low when the filtered fall completes, the block stays in normal mode.
- R7: A wake pulse on `wake_loc_i` or `wake_rem_i` in sleep moves the block to fail-safe on the next edge. `inh_on_o` becomes 1 and `rxd_low_o` becomes 1 while `en_i` is low.
- R8: `txd_pd_o` is 1 after a local wake and 0 after a remote wake. When both pulses arrive in the same cycle, the wake counts as local.
- R9: `rxd_low_o` and `txd_pd_o` drop in the same cycle that `en_i` goes high, with no clock edge needed, and they stay 0 after that.
- R10: Wake pulses outside sleep mode change neither the mode nor the wake indications.
- R11: In sleep, `en_i` high for RISE_US ticks with no wake pulse moves the block to normal one edge after the completing tick, with no wake indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_us_i | input | 1 | One-cycle pulse every microsecond |
| vs_low_i | input | 1 | Supply below undervoltage threshold |
| en_i | input | 1 | Enable pin level (disconnected reads 0) |
| txd_i | input | 1 | Transmit input level |
| wake_loc_i | input | 1 | Filtered local wake request pulse |
| wake_rem_i | input | 1 | Filtered remote (bus) wake request pulse |
| mode_o | output | 2 | Current mode code |
| tx_en_o | output | 1 | Transmit path enable |
| rx_en_o | output | 1 | Receive path enable |
| inh_on_o | output | 1 | Regulator inhibit switch on |
| rxd_low_o | output | 1 | Force receive pin low (wake request) |
| txd_pd_o | output | 1 | Strong pull-down on transmit pin (local wake) |

## Verification
Each result has a fixed due point. Fail-safe after power-up lands on the edge of the PWRUP_US-th tick. Normal lands one edge after the RISE_US-th tick of a high enable. Sleep lands on the edge of the FALL_US-th tick of a low enable. Fail-safe after a wake lands one edge after the pulse, and the wake indications drop combinationally in the cycle that enable rises. The bench keeps the tick high so that ticks equal edges. It drives and samples 2 ns after each rising edge and checks one cycle before each due edge as well as on it. It sweeps the enable pulse width across both filter thresholds and compares the resulting mode with the width-versus-limit arithmetic.

// File: rtl/xcvr_mode_pkg.sv
package xcvr_mode_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_SAFE  = 2'b01,
    MODE_RUN   = 2'b10,
    MODE_SLEEP = 2'b11
  } mode_e;
endpackage

// File: rtl/xcvr_en_filter.sv
module xcvr_en_filter #(
  parameter int RISE_US = 7,
  parameter int FALL_US = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int MAX_US = (RISE_US > FALL_US) ? RISE_US : FALL_US;
  localparam int CW = $clog2(MAX_US + 1);
  localparam logic [CW-1:0] RISE_LIM = CW'(RISE_US - 1);
  localparam logic [CW-1:0] FALL_LIM = CW'(FALL_US - 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_q;
  logic          differ, done;

  assign differ = en_i ^ lvl_q;
  assign done   = differ && tick_i && (cnt_q == (lvl_q ? FALL_LIM : RISE_LIM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (!differ) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (done) begin
        lvl_q <= ~lvl_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level_o = lvl_q;
  assign rise_o  = done & ~lvl_q;
  assign fall_o  = done & lvl_q;

  // filtered level only ever moves toward the raw pin
  assert_level_follows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lvl_q) |-> ($past(en_i) == lvl_q));
endmodule

// File: rtl/xcvr_pwrup_timer.sv
module xcvr_pwrup_timer #(
  parameter int PWRUP_US = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic arm_i,
  output logic done_o
);
  localparam int CW = $clog2(PWRUP_US + 1);
  localparam logic [CW-1:0] LIM = CW'(PWRUP_US - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!arm_i)        cnt_q <= '0;
    else if (tick_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = arm_i && tick_i && (cnt_q == LIM);
endmodule

// File: rtl/xcvr_wake_flags.sv
module xcvr_wake_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_loc_i,
  input  logic set_rem_i,
  input  logic clr_i,
  input  logic en_i,
  output logic rxd_low_o,
  output logic txd_pd_o
);
  logic req_q, loc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      loc_q <= 1'b0;
    end else if (clr_i) begin
      req_q <= 1'b0;
      loc_q <= 1'b0;
    end else if (set_loc_i || set_rem_i) begin
      req_q <= 1'b1;
      loc_q <= set_loc_i;  // local wins on a tie
    end
  end

  // enable high releases both pins without waiting for an edge
  assign rxd_low_o = req_q & ~en_i;
  assign txd_pd_o  = req_q & loc_q & ~en_i;

  assert_src_needs_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txd_pd_o |-> rxd_low_o);
  assert_release_on_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (!rxd_low_o && !txd_pd_o));
endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
  import xcvr_mode_pkg::*;
#(
  parameter int RISE_US  = 7,
  parameter int FALL_US  = 7,
  parameter int PWRUP_US = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_us_i,
  input  logic       vs_low_i,
  input  logic       en_i,
  input  logic       txd_i,
  input  logic       wake_loc_i,
  input  logic       wake_rem_i,
  output logic [1:0] mode_o,
  output logic       tx_en_o,
  output logic       rx_en_o,
  output logic       inh_on_o,
  output logic       rxd_low_o,
  output logic       txd_pd_o
);
  mode_e mode_q, mode_d;
  logic  en_lvl, en_rise, en_fall, pw_done, any_wake, wake_ok;

  xcvr_en_filter #(.RISE_US(RISE_US), .FALL_US(FALL_US)) u_en_filt (
    .clk_i, .rst_ni, .tick_i(tick_us_i), .en_i,
    .level_o(en_lvl), .rise_o(en_rise), .fall_o(en_fall)
  );

  xcvr_pwrup_timer #(.PWRUP_US(PWRUP_US)) u_pwrup (
    .clk_i, .rst_ni, .tick_i(tick_us_i),
    .arm_i(mode_q == MODE_OFF && !vs_low_i), .done_o(pw_done)
  );

  assign any_wake = wake_loc_i | wake_rem_i;
  assign wake_ok  = (mode_q == MODE_SLEEP) && !vs_low_i;

  xcvr_wake_flags u_wake (
    .clk_i, .rst_ni,
    .set_loc_i(wake_ok & wake_loc_i), .set_rem_i(wake_ok & wake_rem_i),
    .clr_i(en_i | vs_low_i), .en_i,
    .rxd_low_o, .txd_pd_o
  );

  always_comb begin
    mode_d = mode_q;
    if (vs_low_i) mode_d = MODE_OFF;
    else begin
      unique case (mode_q)
        MODE_OFF:   if (pw_done) mode_d = MODE_SAFE;
        MODE_SAFE:  if (en_lvl)  mode_d = MODE_RUN;
        MODE_RUN:   if (en_fall && txd_i) mode_d = MODE_SLEEP;
        MODE_SLEEP: if (any_wake) mode_d = MODE_SAFE;
                    else if (en_lvl) mode_d = MODE_RUN;
        default:    mode_d = MODE_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_OFF;
    else         mode_q <= mode_d;
  end

  assign mode_o   = mode_q;
  assign tx_en_o  = (mode_q == MODE_RUN);
  assign rx_en_o  = (mode_q == MODE_RUN);
  assign inh_on_o = (mode_q == MODE_SAFE) || (mode_q == MODE_RUN);

  assert_undervolt_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_low_i |=> (mode_o == 2'b00 && !inh_on_o));
  assert_sleep_entry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SLEEP && $past(mode_q) != MODE_SLEEP) |->
      ($past(mode_q) == MODE_RUN && $past(txd_i)));
  assert_wake_exit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SLEEP && !vs_low_i && any_wake) |=> (mode_q == MODE_SAFE && inh_on_o));
  assert_comm_needs_inh_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o || rx_en_o) |-> inh_on_o);
  assert_wake_only_safe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxd_low_o |-> (mode_q == MODE_SAFE));
endmodule

// File: tb/sim_xcvr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_xcvr_mode_ctrl;
  localparam int P_RISE = 3;
  localparam int P_FALL = 4;
  localparam int P_PWR  = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick = 1'b1, vs_low = 1'b1, en = 1'b0, txd = 1'b1, wloc = 1'b0, wrem = 1'b0;
  logic [1:0] mode;
  logic tx_en, rx_en, inh, rxd_low, txd_pd;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  xcvr_mode_ctrl #(.RISE_US(P_RISE), .FALL_US(P_FALL), .PWRUP_US(P_PWR)) u0 (
    .clk_i(clk), .rst_ni, .tick_us_i(tick), .vs_low_i(vs_low), .en_i(en), .txd_i(txd),
    .wake_loc_i(wloc), .wake_rem_i(wrem), .mode_o(mode), .tx_en_o(tx_en),
    .rx_en_o(rx_en), .inh_on_o(inh), .rxd_low_o(rxd_low), .txd_pd_o(txd_pd)
  );

  function automatic logic [6:0] exp_of(logic [1:0] m, logic rl, logic pd);
    return {m, m == 2'b10, m == 2'b10, (m == 2'b01) || (m == 2'b10), rl, pd};
  endfunction

  task automatic chk(string req, logic [6:0] exp);
    logic [6:0] act;
    act = {mode, tx_en, rx_en, inh, rxd_low, txd_pd};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {mode,tx,rx,inh,rxd,txd}=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic go_safe();
    vs_low = 1'b1; en = 1'b0; wloc = 1'b0; wrem = 1'b0;
    step(P_FALL + 1);
    vs_low = 1'b0;
    step(P_PWR);
  endtask

  task automatic go_run();
    go_safe();
    en = 1'b1;
    step(P_RISE + 1);
  endtask

  task automatic go_sleep();
    txd = 1'b1; en = 1'b0;
    step(P_FALL);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #10;
    chk("R1 reset", exp_of(2'b00, 0, 0));
    @(posedge clk); #2 rst_ni = 1'b1;
    step(3);
    chk("R1 undervoltage held", exp_of(2'b00, 0, 0));
    vs_low = 1'b0;
    step(P_PWR - 1);
    chk("R2 before delay", exp_of(2'b00, 0, 0));
    step(1);
    chk("R2 power-up", exp_of(2'b01, 0, 0));

    // R3: no tick, no progress
    tick = 1'b0; en = 1'b1;
    step(10);
    chk("R3 stalled without tick", exp_of(2'b01, 0, 0));
    tick = 1'b1;
    step(P_RISE);
    chk("R3 filter edge", exp_of(2'b01, 0, 0));
    step(1);
    chk("R4 normal", exp_of(2'b10, 0, 0));

    // R6: fall with txd low
    txd = 1'b0; en = 1'b0;
    step(P_FALL + 3);
    chk("R6 txd low blocks sleep", exp_of(2'b10, 0, 0));
    en = 1'b1;
    step(P_RISE + 1);
    txd = 1'b1; en = 1'b0;
    step(P_FALL - 1);
    en = 1'b1;
    step(3);
    chk("R5 short low ignored", exp_of(2'b10, 0, 0));

    // R10: wake outside sleep
    wloc = 1'b1; step(1); wloc = 1'b0; wrem = 1'b1; step(1); wrem = 1'b0;
    chk("R10 wake in normal", exp_of(2'b10, 0, 0));

    en = 1'b0;
    step(P_FALL - 1);
    chk("R5 before fall", exp_of(2'b10, 0, 0));
    step(1);
    chk("R5 sleep entry", exp_of(2'b11, 0, 0));
    step(5);
    chk("R5 sleep held", exp_of(2'b11, 0, 0));

    // R7/R8 local wake
    wloc = 1'b1; step(1); wloc = 1'b0;
    chk("R7 local wake", exp_of(2'b01, 1, 1));
    step(4);
    chk("R8 local source held", exp_of(2'b01, 1, 1));
    en = 1'b1; #1;
    chk("R9 immediate release", exp_of(2'b01, 0, 0));
    step(1);
    chk("R9 still released", exp_of(2'b01, 0, 0));
    step(P_RISE);
    chk("R3 normal after wake", exp_of(2'b10, 0, 0));

    // R8 remote wake
    go_sleep();
    chk("R5 second sleep", exp_of(2'b11, 0, 0));
    wrem = 1'b1; step(1); wrem = 1'b0;
    chk("R8 remote source", exp_of(2'b01, 1, 0));
    en = 1'b1; step(P_RISE + 1);
    go_sleep();
    wloc = 1'b1; wrem = 1'b1; step(1); wloc = 1'b0; wrem = 1'b0;
    chk("R8 both pulses count local", exp_of(2'b01, 1, 1));

    // R1/R2 clears flags
    vs_low = 1'b1; step(1);
    chk("R1 undervoltage from fail-safe", exp_of(2'b00, 0, 0));
    vs_low = 1'b0; step(P_PWR);
    chk("R2 flags cleared", exp_of(2'b01, 0, 0));

    // R11 sleep to normal via enable
    en = 1'b1; step(P_RISE + 1);
    go_sleep();
    en = 1'b1; step(P_RISE);
    chk("R11 before filter", exp_of(2'b11, 0, 0));
    step(1);
    chk("R11 sleep to normal", exp_of(2'b10, 0, 0));
    vs_low = 1'b1; step(1);
    chk("R1 undervoltage from normal", exp_of(2'b00, 0, 0));

    // R3 sweep of enable high width
    for (int w = 1; w <= P_RISE + 2; w++) begin
      go_safe();
      txd = 1'b0; en = 1'b1;
      step(w);
      en = 1'b0;
      step(2);
      chk("R3 width sweep", exp_of((w >= P_RISE) ? 2'b10 : 2'b01, 0, 0));
    end

    // R5 sweep of enable low width
    for (int w = 1; w <= P_FALL + 2; w++) begin
      go_run();
      txd = 1'b1; en = 1'b0;
      step(w);
      en = 1'b1;
      step(1);
      chk("R5 width sweep", exp_of((w >= P_FALL) ? 2'b11 : 2'b10, 0, 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule